// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block is a single-channel pulse-width modulator controlled through a small register bus. Software picks a counting clock from three tick-enable inputs and divides it with a 12-bit prescaler. It sets a period and then feeds duty values into a four-entry queue. A 16-bit counter steps once per prescaled tick and runs through the period value plus two. The output is high from each rollover until the counter reaches the active duty value.

At each reload point the block takes the next duty value from the queue. A repeat setting controls how many periods each value is used for: one, two, four or eight. If the queue is empty at a reload point, the last value stays in use. Sticky status flags record write overflow, compare hits, rollovers and an empty queue at reload. Writing 1 to a flag clears it. A self-clearing software reset returns every register to its reset value and empties the queue.

Top module: `pwm_fifo_gen`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x0C (sample) and 0x10 (period). After hardware reset, control and status both read 0.
- R2: A period field value P gives an output period of P+2 counter steps. A prescale field value N in control bits [15:4] makes one counter step every N+1 ticks of the selected source.
- R3: A period value of 0xFFFF behaves exactly like 0xFFFE, giving 65536 steps per period.
- R4: Control bits [17:16] choose the counting tick. 0 stops counting. 1 selects tick_bus, 2 selects tick_fast and 3 selects tick_slow.
- R5: Control bits [19:18] choose the output mode. In mode 0 the output is high while the counter is below the active sample, which means it goes high at rollover and low when the counter reaches the sample. Mode 1 gives the complement. Modes 2 and 3 hold the output low.
- R6: While control bit 0 (enable) is 0, the output is low in every mode.
- R7: The sample queue holds four 16-bit entries, and status bits [2:0] give the count. A sample write made while the count is 4 is discarded and sets status bit 6.
- R8: Control bits [2:1] select 1, 2, 4 or 8 uses of each sample. Setting the enable bit loads the first sample. Every later load happens at the rollover that ends the last use. If a load finds the queue empty, the previous sample is kept and status bit 3 is set.
- R9: Status bit 5 is set when a counter step lands on the sample value. Status bit 4 is set on each rollover. Writing 1 to any of status bits 3 to 6 clears that bit.
- R10: Writing 1 to control bit 3 resets all registers and empties the queue. Bit 3 then reads 1 for SWR_CYCLES cycles and clears itself. Control writes made during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_bus | input | 1 | Tick enable for source 1 |
| tick_fast | input | 1 | Tick enable for source 2 |
| tick_slow | input | 1 | Tick enable for source 3 |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume that the tick inputs are synchronous to clk and that every write strobe lasts exactly one cycle with a stable address. The queue-overflow property also assumes that a sample write and a software reset never arrive in the same cycle. The stimulus follows these rules. Every bus access is driven on the falling edge and held for one full cycle. The tick patterns come from a free-running counter in the clock domain. Each software reset finishes before the next sample write is issued.

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen #(
  parameter int DEPTH = 4,
  parameter int SWR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_bus,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(SWR_CYCLES + 1);

  logic        en;
  logic [1:0]  rpt, src, mode;
  logic [11:0] presc;
  logic [15:0] per, act, cnt;
  logic [11:0] pre_cnt;
  logic [2:0]  rep;
  logic        primed;
  logic [SW-1:0] swr_cnt;
  logic        werr, cmp, rov, fe;
  logic [15:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fcnt;

  wire busy   = swr_cnt != '0;
  wire wr_ctl = bus_we && bus_addr == 5'h00;
  wire wr_st  = bus_we && bus_addr == 5'h04;
  wire wr_smp = bus_we && bus_addr == 5'h0C;
  wire wr_per = bus_we && bus_addr == 5'h10;
  wire clr    = busy || (wr_ctl && bus_wdata[3]);

  wire [15:0] last_cnt = ((per == 16'hFFFF) ? 16'hFFFE : per) + 16'd1;
  wire        src_tick = (src == 2'd1) ? tick_bus :
                         (src == 2'd2) ? tick_fast :
                         (src == 2'd3) ? tick_slow : 1'b0;
  wire        run   = en && primed && !busy;
  wire        prime = en && !primed && !busy;
  wire        step  = run && src_tick && pre_cnt >= presc;
  wire        wrap  = cnt >= last_cnt;
  wire [15:0] nxt   = wrap ? 16'd0 : cnt + 16'd1;
  wire [2:0]  rep_last = 3'((4'd1 << rpt) - 4'd1);
  wire        reload = prime || (step && wrap && rep == rep_last);
  wire        full  = fcnt == CW'(DEPTH);
  wire        push  = wr_smp && !clr && !full;
  wire        pop   = reload && fcnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swr_cnt <= '0;
    else if (wr_ctl && bus_wdata[3] && !busy) swr_cnt <= SW'(SWR_CYCLES);
    else if (busy) swr_cnt <= swr_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; rpt <= '0; src <= '0; mode <= '0; presc <= '0; per <= '0;
    end else if (clr) begin
      en <= 1'b0; rpt <= '0; src <= '0; mode <= '0; presc <= '0; per <= '0;
    end else begin
      if (wr_ctl) begin
        en    <= bus_wdata[0];
        rpt   <= bus_wdata[2:1];
        presc <= bus_wdata[15:4];
        src   <= bus_wdata[17:16];
        mode  <= bus_wdata[19:18];
      end
      if (wr_per) per <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= bus_wdata[15:0];
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pre_cnt <= '0; rep <= '0; primed <= 1'b0; act <= '0;
    end else if (clr) begin
      cnt <= '0; pre_cnt <= '0; rep <= '0; primed <= 1'b0; act <= '0;
    end else if (!en) begin
      cnt <= '0; pre_cnt <= '0; rep <= '0; primed <= 1'b0;
    end else begin
      if (prime) primed <= 1'b1;
      if (pop) act <= mem[rp];
      if (run && src_tick) pre_cnt <= step ? 12'd0 : pre_cnt + 12'd1;
      if (step) begin
        cnt <= nxt;
        if (wrap) rep <= (rep == rep_last) ? 3'd0 : rep + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      werr <= 1'b0; cmp <= 1'b0; rov <= 1'b0; fe <= 1'b0;
    end else if (clr) begin
      werr <= 1'b0; cmp <= 1'b0; rov <= 1'b0; fe <= 1'b0;
    end else begin
      werr <= (wr_smp && full) || (werr && !(wr_st && bus_wdata[6]));
      cmp  <= (step && nxt == act) || (cmp && !(wr_st && bus_wdata[5]));
      rov  <= (step && wrap) || (rov && !(wr_st && bus_wdata[4]));
      fe   <= (reload && fcnt == '0) || (fe && !(wr_st && bus_wdata[3]));
    end
  end

  wire raw = cnt < act;
  assign pwm_out = en && ((mode == 2'd0) ? raw : (mode == 2'd1) ? !raw : 1'b0);

  always_comb begin
    case (bus_addr)
      5'h00:   bus_rdata = {12'd0, mode, src, presc, busy, rpt, en};
      5'h04:   bus_rdata = {25'd0, werr, cmp, rov, fe, 3'(fcnt)};
      5'h0C:   bus_rdata = {16'd0, act};
      5'h10:   bus_rdata = {16'd0, per};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

module pwm_fifo_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] mode,
  input logic       busy,
  input logic [2:0] fcnt,
  input logic       werr,
  input logic       bus_we,
  input logic [4:0] bus_addr,
  input logic       pwm_out
);
  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= 3'd4);
  assert_full_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h0C && fcnt == 3'd4 && !busy) |=> werr);
  assert_low_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);
  assert_mode_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && en) |-> !pwm_out);
  assert_reset_flushes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fcnt == 3'd0 && !en));
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .busy(busy),
  .fcnt(3'(fcnt)), .werr(werr), .bus_we(bus_we), .bus_addr(bus_addr),
  .pwm_out(pwm_out)
);

// File: tb/pwm_fifo_gen_test.sv
`timescale 1ns/1ps
module pwm_fifo_gen_test;
  logic clk = 0, rst_n = 0;
  logic tick_bus = 1, tick_fast = 0, tick_slow = 0;
  logic bus_we = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic pwm_out;

  pwm_fifo_gen uut (.clk(clk), .rst_n(rst_n), .tick_bus(tick_bus), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #2.5 clk = ~clk;

  int total = 0, failed = 0;
  int exp_hi[$], exp_per[$];
  string exp_tag[$];
  bit armed = 0, started = 0, prev = 0, done = 0;
  int skip = 0, hi_c = 0, per_c = 0, cyc = 0;

  task automatic check(input string req, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic push_exp(input int hi, input int p, input string tag);
    exp_hi.push_back(hi); exp_per.push_back(p); exp_tag.push_back(tag);
  endtask

  task automatic run_scoreboard();
    started = 0; skip = 1; armed = 1;
    while (exp_hi.size() != 0) @(negedge clk);
    armed = 0;
  endtask

  task automatic soft_reset();
    wr(5'h00, 32'h8);
    repeat (8) @(negedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    tick_fast = (cyc % 2) == 0;
    tick_slow = (cyc % 4) == 0;
  end

  initial forever begin
    @(negedge clk);
    if (armed) begin
      if (pwm_out && !prev) begin
        if (started) begin
          if (skip > 0) skip--;
          else if (exp_hi.size() != 0) begin
            string t;
            int h, p;
            h = exp_hi.pop_front(); p = exp_per.pop_front(); t = exp_tag.pop_front();
            check({t, " high"}, hi_c, h);
            check({t, " period"}, per_c, p);
          end
        end
        started = 1; hi_c = 0; per_c = 0;
      end
      if (started) begin
        per_c++;
        if (pwm_out) hi_c++;
      end
    end
    prev = pwm_out;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    rd(5'h00, d); check("R1 ctrl reset", d, 0);
    rd(5'h04, d); check("R1 status reset", d, 0);

    // R7 fill queue, overflow write
    for (int i = 1; i <= 4; i++) wr(5'h0C, i);
    rd(5'h04, d); check("R7 count four", d, 32'h04);
    wr(5'h0C, 32'h55);
    rd(5'h04, d); check("R7 overflow flag", d, 32'h44);
    // R9 write-one-to-clear
    wr(5'h04, 32'h40);
    rd(5'h04, d); check("R9 werr cleared", d, 32'h04);

    // R10 software reset
    wr(5'h00, 32'h8);
    rd(5'h00, d); check("R10 busy bit", d, 32'h8);
    repeat (6) @(negedge clk);
    rd(5'h00, d); check("R10 self clear", d, 0);
    rd(5'h04, d); check("R10 flushed", d, 0);

    // R2 R5 R8 basic sequence, src1, prescale 0
    wr(5'h10, 8); wr(5'h0C, 3); wr(5'h0C, 6);
    push_exp(6, 10, "R2 R8 second sample");
    push_exp(6, 10, "R8 keep last");
    wr(5'h00, 32'h10001);
    run_scoreboard();
    wr(5'h00, 32'h10000);
    rd(5'h04, d); check("R8 R9 flags fe rov cmp", d, 32'h38);
    check("R6 low when disabled", pwm_out, 0);
    wr(5'h04, 32'h38);
    rd(5'h04, d); check("R9 flags cleared", d, 0);

    // R8 repeat twice, R2 prescale 1
    soft_reset();
    wr(5'h10, 3); wr(5'h0C, 1); wr(5'h0C, 4);
    push_exp(2, 10, "R8 repeat second use");
    push_exp(8, 10, "R8 next sample");
    push_exp(8, 10, "R2 prescaled period");
    wr(5'h00, 32'h10013);
    run_scoreboard();

    // R5 inverted
    soft_reset();
    wr(5'h10, 8); wr(5'h0C, 3);
    push_exp(7, 10, "R5 inverted");
    push_exp(7, 10, "R5 inverted again");
    wr(5'h00, 32'h50001);
    run_scoreboard();
    wr(5'h00, 32'h90001);
    ok = 1;
    repeat (30) begin @(negedge clk); if (pwm_out) ok = 0; end
    check("R5 mode off low", ok, 1);
    wr(5'h00, 32'h50000);
    ok = 1;
    repeat (20) begin @(negedge clk); if (pwm_out) ok = 0; end
    check("R6 disabled inverted low", ok, 1);

    // R4 source off: counter frozen, output stays high
    soft_reset();
    wr(5'h10, 8); wr(5'h0C, 5);
    wr(5'h00, 32'h1);
    ok = 1;
    repeat (40) begin @(negedge clk); if (!pwm_out) ok = 0; end
    check("R4 source off frozen", ok, 1);

    // R4 slow source
    soft_reset();
    wr(5'h10, 2); wr(5'h0C, 2);
    push_exp(8, 16, "R4 slow tick");
    push_exp(8, 16, "R4 slow tick again");
    wr(5'h00, 32'h30001);
    run_scoreboard();

    // R4 fast source
    soft_reset();
    wr(5'h10, 2); wr(5'h0C, 1);
    push_exp(2, 8, "R4 fast tick");
    wr(5'h00, 32'h20001);
    run_scoreboard();

    // R3 clamp of 0xFFFF
    soft_reset();
    wr(5'h10, 32'hFFFF); wr(5'h0C, 32'hFFFF);
    wr(5'h00, 32'h10001);
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    n = 0;
    while (pwm_out) begin n++; @(negedge clk); end
    check("R3 high span", n, 65535);
    n = 0;
    while (!pwm_out) begin n++; @(negedge clk); end
    check("R3 low span", n, 1);

    finish_run();
  end
endmodule